// File: doc/BRIEF.md
# Packet-Filter VM Branch Resolution Unit

This unit decides where a packet-filter virtual machine goes after a jump-class instruction. It receives the decoded fields of one instruction (4-bit operation, source-select bit, jump-class bit, 16-bit displacement, 32-bit immediate), the two operand register values and the current program counter, which counts instructions. One clock later it returns the next program counter, a taken flag, and flags for call, exit and illegal encodings.

The jump class chooses the operand width. In the wide class, comparisons use full 64-bit operands. In the narrow class, they use only the low 32 bits, and bit 31 is the sign. When the source bit is clear, the second operand is the sign-extended immediate. The unconditional jump has two forms. The short form adds the 16-bit displacement. The long form is encoded in the narrow class with the source bit set, and it adds the full 32-bit immediate, which reaches about two billion instructions in either direction.

Calls and exits are only flagged here. The pipeline around the unit handles them, and it also owns the register file.

Top module: `pfvm_branch_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output is driven to zero in the following cycle.
- R2: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. Results are registered with one cycle of latency.
- R3: When `taken` is low, `next_pc` equals the input PC plus one, modulo 2^PC_W.
- R4: Unsigned conditions are taken when they hold. Greater-than is op 0x2, greater-or-equal is 0x3, less-than is 0xa and less-or-equal is 0xb.
- R5: Equal (0x1) and not-equal (0x5) compare the operands. Bit-test (0x4) is taken when the AND of the operands is nonzero. The signed forms are greater-than 0x6, greater-or-equal 0x7, less-than 0xc and less-or-equal 0xd, and they compare in two's complement.
- R6: With `src_sel` low, the second operand is the 32-bit immediate sign-extended to the operand width. With `src_sel` high, it is `src_val`.
- R7: With `cls32` high, comparisons use only bits 31:0 of both operands, and signed comparisons take bit 31 as the sign.
- R8: A taken conditional branch gives `next_pc` = PC + 1 + the sign-extended 16-bit `off`.
- R9: Op 0x0 with `cls32` low is always taken with PC + 1 + sign-extended `off`. Op 0x0 with `cls32` high and `src_sel` high is always taken with PC + 1 + sign-extended `imm`.
- R10: Op 0x8 with `cls32` low raises `is_call`. Op 0x9 with `cls32` low raises `is_exit`. In both cases `taken` is low.
- R11: `illegal` is raised, and `taken` is low, for these encodings: op 0x0 with `cls32` high and `src_sel` low, op 0x8 or 0x9 with `cls32` high, and op 0xe or 0xf.
- R12: At most one of `taken`, `is_call`, `is_exit` and `illegal` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction fields are valid this cycle |
| op | input | 4 | Jump operation code |
| src_sel | input | 1 | 1: second operand is src_val; 0: immediate |
| cls32 | input | 1 | 1: narrow (32-bit) jump class; 0: wide class |
| off | input | OFF_W (16) | Signed short displacement |
| imm | input | IMM_W (32) | Immediate operand or long displacement |
| dst_val | input | DATA_W (64) | First operand |
| src_val | input | DATA_W (64) | Second operand register value |
| pc | input | PC_W (32) | Current program counter in instructions |
| out_valid | output | 1 | Result valid |
| next_pc | output | PC_W (32) | Resolved next program counter |
| taken | output | 1 | Branch or jump taken |
| is_call | output | 1 | Call instruction seen |
| is_exit | output | 1 | Exit instruction seen |
| illegal | output | 1 | Encoding not allowed in this class |

## Verification
The bench uses the default parameters: 64-bit operands, a 32-bit PC, a 16-bit displacement and a 32-bit immediate. With these widths the narrow class differs from the wide class in visible ways. Operands that agree in their low 32 bits compare equal only in the narrow class. A value with bit 31 set is negative only in the narrow class. A long jump whose immediate goes past the 16-bit displacement range, or wraps the 32-bit PC, produces a target the short form cannot reach. The random patterns skew operands toward equal, adjacent and sign-boundary values so that the edges of every comparison are exercised.

// File: rtl/pfvm_br_pkg.sv
package pfvm_br_pkg;
  typedef enum logic [3:0] {
    OP_JA   = 4'h0, OP_JEQ  = 4'h1, OP_JGT  = 4'h2, OP_JGE  = 4'h3,
    OP_JSET = 4'h4, OP_JNE  = 4'h5, OP_JSGT = 4'h6, OP_JSGE = 4'h7,
    OP_CALL = 4'h8, OP_EXIT = 4'h9, OP_JLT  = 4'ha, OP_JLE  = 4'hb,
    OP_JSLT = 4'hc, OP_JSLE = 4'hd, OP_RSVE = 4'he, OP_RSVF = 4'hf
  } br_op_e;

  typedef struct packed {
    logic is_cond;
    logic is_jump;
    logic long_disp;
    logic is_call;
    logic is_exit;
    logic illegal;
  } br_kind_t;
endpackage

// File: rtl/pfvm_br_decode.sv
module pfvm_br_decode
  import pfvm_br_pkg::*;
(
  input  logic [3:0] op_i,
  input  logic       src_sel_i,
  input  logic       cls32_i,
  output br_kind_t   kind_o
);
  always_comb begin
    kind_o = '0;
    unique case (br_op_e'(op_i))
      OP_JA: begin
        if (!cls32_i) kind_o.is_jump = 1'b1;
        else if (src_sel_i) begin
          kind_o.is_jump   = 1'b1;
          kind_o.long_disp = 1'b1;
        end else kind_o.illegal = 1'b1;
      end
      OP_CALL: begin
        if (cls32_i) kind_o.illegal = 1'b1;
        else         kind_o.is_call = 1'b1;
      end
      OP_EXIT: begin
        if (cls32_i) kind_o.illegal = 1'b1;
        else         kind_o.is_exit = 1'b1;
      end
      OP_RSVE, OP_RSVF: kind_o.illegal = 1'b1;
      default: kind_o.is_cond = 1'b1;
    endcase
  end
endmodule

// File: rtl/pfvm_br_cmp.sv
module pfvm_br_cmp
  import pfvm_br_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic [3:0]        op_i,
  input  logic              narrow_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              hit_o
);
  localparam int PAD_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0] a_u, b_u, a_s, b_s;
  logic eq, ugt, sgt, any;

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb begin
        a_u = narrow_i ? {{PAD_W{1'b0}}, a_i[NARROW_W-1:0]} : a_i;
        b_u = narrow_i ? {{PAD_W{1'b0}}, b_i[NARROW_W-1:0]} : b_i;
        a_s = narrow_i ? {{PAD_W{a_i[NARROW_W-1]}}, a_i[NARROW_W-1:0]} : a_i;
        b_s = narrow_i ? {{PAD_W{b_i[NARROW_W-1]}}, b_i[NARROW_W-1:0]} : b_i;
      end
    end else begin : g_nopad
      always_comb begin
        a_u = a_i; b_u = b_i; a_s = a_i; b_s = b_i;
      end
    end
  endgenerate

  assign eq  = (a_u == b_u);
  assign ugt = (a_u > b_u);
  assign sgt = ($signed(a_s) > $signed(b_s));
  assign any = |(a_u & b_u);

  always_comb begin
    unique case (br_op_e'(op_i))
      OP_JEQ:  hit_o = eq;
      OP_JNE:  hit_o = !eq;
      OP_JSET: hit_o = any;
      OP_JGT:  hit_o = ugt;
      OP_JGE:  hit_o = ugt | eq;
      OP_JLT:  hit_o = !(ugt | eq);
      OP_JLE:  hit_o = !ugt;
      OP_JSGT: hit_o = sgt;
      OP_JSGE: hit_o = sgt | eq;
      OP_JSLT: hit_o = !(sgt | eq);
      OP_JSLE: hit_o = !sgt;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pfvm_br_target.sv
module pfvm_br_target #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 16,
  parameter int IMM_W = 32
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             long_i,
  output logic [PC_W-1:0]  seq_o,
  output logic [PC_W-1:0]  tgt_o
);
  logic [PC_W-1:0] d_short, d_long;
  assign d_short = PC_W'($signed(off_i));
  assign d_long  = PC_W'($signed(imm_i));
  assign seq_o   = pc_i + PC_W'(1);
  assign tgt_o   = seq_o + (long_i ? d_long : d_short);
endmodule

// File: rtl/pfvm_branch_unit.sv
module pfvm_branch_unit
  import pfvm_br_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int PC_W     = 32,
  parameter int OFF_W    = 16,
  parameter int IMM_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic              src_sel,
  input  logic              cls32,
  input  logic [OFF_W-1:0]  off,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [PC_W-1:0]   pc,
  output logic              out_valid,
  output logic [PC_W-1:0]   next_pc,
  output logic              taken,
  output logic              is_call,
  output logic              is_exit,
  output logic              illegal
);
  br_kind_t          kind;
  logic [DATA_W-1:0] opnd_b;
  logic              cond_hit, take_c;
  logic [PC_W-1:0]   seq_pc, tgt_pc;

  assign opnd_b = src_sel ? src_val : DATA_W'($signed(imm));

  pfvm_br_decode u_dec (
    .op_i(op), .src_sel_i(src_sel), .cls32_i(cls32), .kind_o(kind)
  );

  pfvm_br_cmp #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cmp (
    .op_i(op), .narrow_i(cls32), .a_i(dst_val), .b_i(opnd_b), .hit_o(cond_hit)
  );

  pfvm_br_target #(.PC_W(PC_W), .OFF_W(OFF_W), .IMM_W(IMM_W)) u_tgt (
    .pc_i(pc), .off_i(off), .imm_i(imm), .long_i(kind.long_disp),
    .seq_o(seq_pc), .tgt_o(tgt_pc)
  );

  assign take_c = kind.is_jump | (kind.is_cond & cond_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      next_pc   <= '0;
      taken     <= 1'b0;
      is_call   <= 1'b0;
      is_exit   <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        next_pc <= take_c ? tgt_pc : seq_pc;
        taken   <= take_c;
        is_call <= kind.is_call;
        is_exit <= kind.is_exit;
        illegal <= kind.illegal;
      end
    end
  end
endmodule

module pfvm_branch_unit_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [3:0]      op,
  input logic            src_sel,
  input logic            cls32,
  input logic [PC_W-1:0] pc,
  input logic            out_valid,
  input logic [PC_W-1:0] next_pc,
  input logic            taken,
  input logic            is_call,
  input logic            is_exit,
  input logic            illegal
);
  // R12
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0({taken, is_call, is_exit, illegal}));
  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid) && !$past(rst) |-> out_valid);
  // R3
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !taken |-> next_pc == $past(pc) + PC_W'(1));
  // R10
  call_wide_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && (is_call || is_exit) |-> !$past(cls32));
  // R11
  illegal_src_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && illegal |-> $past(cls32) || $past(op) >= 4'he);
  // R9
  ja_taken_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(op) == 4'h0 && (!$past(cls32) || $past(src_sel)) |-> taken);
endmodule

bind pfvm_branch_unit pfvm_branch_unit_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .src_sel(src_sel),
  .cls32(cls32), .pc(pc), .out_valid(out_valid), .next_pc(next_pc),
  .taken(taken), .is_call(is_call), .is_exit(is_exit), .illegal(illegal)
);

// File: tb/pfvm_branch_unit_test.sv
module pfvm_branch_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic        src_sel = 1'b0;
  logic        cls32 = 1'b0;
  logic [15:0] off = '0;
  logic [31:0] imm = '0;
  logic [63:0] dst_val = '0, src_val = '0;
  logic [31:0] pc = '0;
  logic        out_valid, taken, is_call, is_exit, illegal;
  logic [31:0] next_pc;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pfvm_branch_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .src_sel(src_sel),
    .cls32(cls32), .off(off), .imm(imm), .dst_val(dst_val), .src_val(src_val),
    .pc(pc), .out_valid(out_valid), .next_pc(next_pc), .taken(taken),
    .is_call(is_call), .is_exit(is_exit), .illegal(illegal)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  // Reference condition (R4, R5, R6, R7)
  function automatic bit ref_cond(logic [3:0] o, bit s, bit n,
                                  logic [63:0] a, logic [63:0] r, logic [31:0] im);
    logic [63:0] b, au, bu;
    logic signed [63:0] as_, bs_;
    b   = s ? r : {{32{im[31]}}, im};
    au  = n ? {32'h0, a[31:0]} : a;
    bu  = n ? {32'h0, b[31:0]} : b;
    as_ = n ? {{32{a[31]}}, a[31:0]} : a;
    bs_ = n ? {{32{b[31]}}, b[31:0]} : b;
    case (o)
      4'h1: return au == bu;
      4'h5: return au != bu;
      4'h4: return (au & bu) != 0;
      4'h2: return au > bu;
      4'h3: return au >= bu;
      4'ha: return au < bu;
      4'hb: return au <= bu;
      4'h6: return as_ > bs_;
      4'h7: return as_ >= bs_;
      4'hc: return as_ < bs_;
      4'hd: return as_ <= bs_;
      default: return 0;
    endcase
  endfunction

  task automatic run(string tag);
    bit t, c, e, il;
    logic [31:0] np;
    t = 0; c = 0; e = 0; il = 0;
    np = pc + 32'd1;
    if (op == 4'h0) begin
      if (!cls32) begin t = 1; np = pc + 32'd1 + {{16{off[15]}}, off}; end
      else if (src_sel) begin t = 1; np = pc + 32'd1 + imm; end
      else il = 1;
    end else if (op == 4'h8 || op == 4'h9) begin
      if (cls32) il = 1; else if (op == 4'h8) c = 1; else e = 1;
    end else if (op >= 4'he) il = 1;
    else if (ref_cond(op, src_sel, cls32, dst_val, src_val, imm)) begin
      t = 1; np = pc + 32'd1 + {{16{off[15]}}, off};
    end
    in_valid = 1'b1;
    @(posedge clk); #1;
    chk({tag, " out_valid"}, 64'(out_valid), 64'd1);
    chk({tag, " taken"},     64'(taken),     64'(t));
    chk({tag, " next_pc"},   64'(next_pc),   64'(np));
    chk({tag, " call/exit/illegal"}, 64'({is_call, is_exit, illegal}), 64'({c, e, il}));
  endtask

  task automatic set_in(logic [3:0] o, bit s, bit n, logic [15:0] of,
                        logic [31:0] im, logic [63:0] a, logic [63:0] r, logic [31:0] p);
    @(negedge clk);
    op = o; src_sel = s; cls32 = n; off = of; imm = im;
    dst_val = a; src_val = r; pc = p;
  endtask

  function automatic logic [63:0] pick64();
    case ($urandom % 6)
      0: return 64'h0;
      1: return 64'h0000_0000_8000_0000;
      2: return 64'hFFFF_FFFF_FFFF_FFFF;
      3: return 64'h8000_0000_0000_0000;
      4: return 64'($urandom % 8);
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk); #1;
    // R1 reset state
    chk("R1 reset outputs", 64'({out_valid, taken, is_call, is_exit, illegal}), 64'd0);
    chk("R1 reset next_pc", 64'(next_pc), 64'd0);
    @(negedge clk); rst = 1'b0;

    // R9 short and long jumps
    set_in(4'h0, 0, 0, 16'h8000, 32'h0, 0, 0, 32'd100);       run("R9 ja short back");
    set_in(4'h0, 1, 1, 16'h0001, 32'h0001_0000, 0, 0, 32'd5); run("R9 ja long fwd");
    set_in(4'h0, 1, 1, 16'h0, 32'h8000_0000, 0, 0, 32'h1234); run("R9 ja long wrap");
    // R11 illegal forms
    set_in(4'h0, 0, 1, 16'h10, 32'h10, 0, 0, 32'd7);          run("R11 ja narrow src0");
    set_in(4'h8, 0, 1, 16'h0, 32'h0, 0, 0, 32'd7);            run("R11 call narrow");
    set_in(4'hf, 1, 0, 16'h4, 32'h0, 0, 0, 32'd7);            run("R11 op f");
    // R10 call / exit
    set_in(4'h8, 0, 0, 16'h4, 32'h3, 0, 0, 32'd9);            run("R10 call");
    set_in(4'h9, 0, 0, 16'h4, 32'h3, 0, 0, 32'd9);            run("R10 exit");
    // R7 narrow equality ignores upper half
    set_in(4'h1, 1, 1, 16'h20, 0, 64'hAAAA_0000_0000_0005, 64'h5, 32'd50); run("R7 jeq narrow");
    set_in(4'h1, 1, 0, 16'h20, 0, 64'hAAAA_0000_0000_0005, 64'h5, 32'd50); run("R5 jeq wide");
    // R7 bit 31 sign in narrow
    set_in(4'hc, 1, 1, 16'hFFF0, 0, 64'h8000_0000, 64'h1, 32'd50); run("R7 jslt narrow");
    set_in(4'hc, 1, 0, 16'hFFF0, 0, 64'h8000_0000, 64'h1, 32'd50); run("R5 jslt wide");
    // R6 immediate sign extension
    set_in(4'h1, 0, 0, 16'h3, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 32'd1); run("R6 jeq imm -1");
    // R4 unsigned boundary
    set_in(4'h3, 1, 0, 16'h7FFF, 0, 64'd7, 64'd7, 32'd0);   run("R4 jge equal");
    set_in(4'ha, 1, 0, 16'h7FFF, 0, 64'd7, 64'd7, 32'd0);   run("R4 jlt equal");
    // R8 / R3 random mix
    for (int i = 0; i < 400; i++) begin
      set_in(4'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
             ($urandom % 3 == 0) ? 32'($urandom % 4) : $urandom,
             pick64(), pick64(), $urandom);
      run((i % 2) ? "R8 random" : "R3 random");
    end
    // R2 idle gives no valid
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1;
    chk("R2 idle out_valid", 64'(out_valid), 64'd0);
    // R12 exclusivity sample
    chk("R12 flags", 64'($countones({taken, is_call, is_exit, illegal}) <= 1), 64'd1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule